// File: doc/BRIEF.md
# Multiplexed LCD display RAM writer

This block is the bit-addressed display memory of a segment LCD driver. It holds four rows, one per backplane, each as wide as the number of segment columns. The host writes bytes through a write strobe. Each byte is packed row-first, most significant bit first, into consecutive columns starting at a column pointer. The pointer then advances by the number of whole columns the byte used. A separate load input sets the pointer directly. With it the host can rewind, so that in 1:3 mode one byte's last column is shared with the start of the next byte.

On the display side, a row sequencer steps through the rows that the current multiplex mode uses. It moves on a frame tick and puts the selected row on a parallel column bus, which feeds the display register. In 1:3 mode rows 0 to 2 are used and row 3 is never selected. In 1:4 mode all four rows are used.

Top module: `lcd_row_ram`

## Requirements
- R1: After reset every RAM bit is 0, the column pointer is 0 and the selected row is 0.
- R2: With `mode4` = 0 (1:3 mode), a write of byte d at pointer p sets rows 0,1,2 of column p to d[7],d[6],d[5]. It sets rows 0,1,2 of column p+1 to d[4],d[3],d[2], and rows 0,1 of column p+2 to d[1],d[0].
- R3: In 1:3 mode a write advances the pointer by 3 and leaves row 2 and row 3 of column p+2 unchanged. Row 3 is never written in 1:3 mode.
- R4: After a pointer rewind to the previous byte's third column, a 1:3 write replaces that column's rows 0 and 1 with the new d[7],d[6] and fills its row 2 with d[5].
- R5: With `mode4` = 1 (1:4 mode), a write sets rows 0..3 of column p to d[7..4] and rows 0..3 of column p+1 to d[3..0], and advances the pointer by 2.
- R6: When `ptr_load` is 1, the pointer takes `ptr_val` next cycle, or 0 if `ptr_val` >= COLS. A write in the same cycle uses the old pointer and does not add its advance.
- R7: Column indices and the pointer wrap modulo COLS, so the column after COLS-1 is 0.
- R8: In 1:3 mode each frame tick moves the selected row 0 -> 1 -> 2 -> 0, and row 3 is never selected.
- R9: In 1:4 mode each frame tick moves the selected row 0 -> 1 -> 2 -> 3 -> 0.
- R10: A change of `mode4` sets the selected row to 0 on the next cycle, taking priority over a frame tick in that cycle. Without a tick or a mode change the row holds.
- R11: `row_data` shows the RAM row named by `row_idx`, bit i being column i, and it reflects a write from the cycle after the write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode4 | input | 1 | 1 = 1:4 multiplex, 0 = 1:3 multiplex |
| wr_en | input | 1 | Byte write strobe |
| wr_data | input | 8 | Byte to pack into the RAM |
| ptr_load | input | 1 | Load the column pointer |
| ptr_val | input | PW | Value for a pointer load |
| frame_tick | input | 1 | Advance the row sequencer |
| ptr | output | PW | Current column pointer |
| row_idx | output | 2 | Row currently selected for display |
| row_data | output | COLS | Selected row, one bit per column |

## Verification
The bench goes after the 1:3 third column. There, a design that advanced by 2 or wrote row 2 would corrupt the unused bits in standard filling, and would lose the overlap value when the pointer is rewound. It writes bytes that straddle the last column, where a design without modulo wrap would drop bits or leave the pointer out of range. It also loads out-of-range pointer values, where such a design would point past the RAM. The row sequencer is driven across mode changes that arrive together with a tick and while row 3 is selected: a wrong design would show row 3 in 1:3 mode or skip row 0.

// File: rtl/lcd_row_ram.sv
module lcd_row_ram #(
  parameter int COLS = 12
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          mode4,
  input  logic                          wr_en,
  input  logic [7:0]                    wr_data,
  input  logic                          ptr_load,
  input  logic [$clog2(COLS)-1:0]       ptr_val,
  input  logic                          frame_tick,
  output logic [$clog2(COLS)-1:0]       ptr,
  output logic [1:0]                    row_idx,
  output logic [COLS-1:0]               row_data
);
  localparam int PW = $clog2(COLS);

  function automatic logic [PW-1:0] col_add(input logic [PW-1:0] p, input int k);
    int s;
    s = int'(p) + k;
    if (s >= COLS) s = s - COLS;
    return PW'(s);
  endfunction

  logic [COLS-1:0] ram [4];
  logic [PW-1:0]   ptr_q;
  logic [1:0]      row_q;
  logic            mode_q;
  logic [PW-1:0]   c0, c1, c2;
  logic [1:0]      last_row;

  assign c0       = ptr_q;
  assign c1       = col_add(ptr_q, 1);
  assign c2       = col_add(ptr_q, 2);
  assign last_row = mode4 ? 2'd3 : 2'd2;
  assign ptr      = ptr_q;
  assign row_idx  = row_q;
  assign row_data = ram[row_q];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < 4; r++) ram[r] <= '0;
    end else if (wr_en) begin
      if (mode4) begin
        ram[0][c0] <= wr_data[7];
        ram[1][c0] <= wr_data[6];
        ram[2][c0] <= wr_data[5];
        ram[3][c0] <= wr_data[4];
        ram[0][c1] <= wr_data[3];
        ram[1][c1] <= wr_data[2];
        ram[2][c1] <= wr_data[1];
        ram[3][c1] <= wr_data[0];
      end else begin
        ram[0][c0] <= wr_data[7];
        ram[1][c0] <= wr_data[6];
        ram[2][c0] <= wr_data[5];
        ram[0][c1] <= wr_data[4];
        ram[1][c1] <= wr_data[3];
        ram[2][c1] <= wr_data[2];
        ram[0][c2] <= wr_data[1];
        ram[1][c2] <= wr_data[0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (ptr_load) begin
      ptr_q <= (int'(ptr_val) < COLS) ? ptr_val : '0;
    end else if (wr_en) begin
      ptr_q <= col_add(ptr_q, mode4 ? 2 : 3);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      row_q  <= '0;
      mode_q <= 1'b0;
    end else begin
      mode_q <= mode4;
      if (mode4 != mode_q)  row_q <= '0;
      else if (frame_tick)  row_q <= (row_q == last_row) ? 2'd0 : row_q + 2'd1;
    end
  end

  p_ptr_in_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    int'(ptr_q) < COLS);

  p_ptr_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_load && int'(ptr_val) < COLS) |=> ptr_q == $past(ptr_val));

  p_adv_three_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !ptr_load && !mode4) |=> ptr_q == col_add($past(ptr_q), 3));

  p_adv_two_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !ptr_load && mode4) |=> ptr_q == col_add($past(ptr_q), 2));

  p_no_row3_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_q |-> row_q != 2'd3);

  p_wrap_four_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode4 && mode_q && frame_tick && row_q == 2'd3) |=> row_q == 2'd0);

  p_mode_reset_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode4 != mode_q) |=> row_q == 2'd0);

  p_row_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_tick && mode4 == mode_q) |=> $stable(row_q));
endmodule

// File: tb/lcd_row_ram_test.sv
module lcd_row_ram_test;
  localparam int COLS = 12;
  localparam int PW = $clog2(COLS);

  logic clk = 0, rst_n = 0, mode4 = 0, wr_en = 0, ptr_load = 0, frame_tick = 0;
  logic [7:0] wr_data = '0;
  logic [PW-1:0] ptr_val = '0;
  logic [PW-1:0] ptr;
  logic [1:0] row_idx;
  logic [COLS-1:0] row_data;

  lcd_row_ram #(.COLS(COLS)) uut (
    .clk(clk), .rst_n(rst_n), .mode4(mode4), .wr_en(wr_en), .wr_data(wr_data),
    .ptr_load(ptr_load), .ptr_val(ptr_val), .frame_tick(frame_tick),
    .ptr(ptr), .row_idx(row_idx), .row_data(row_data));

  always #10 clk = ~clk;

  int tests = 0, fails = 0;
  bit done = 0;

  logic [COLS-1:0] m_ram [4];
  int m_ptr, m_row;
  bit m_modeq;

  function automatic int wrapc(int c);
    return c % COLS;
  endfunction

  task automatic check(string req, string what, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic check_all(string req);
    check(req, "ptr", int'(ptr), m_ptr);
    check(req, "row_idx", int'(row_idx), m_row);
    check(req, "row_data", int'(row_data), int'(m_ram[m_row]));
  endtask

  task automatic model_step(bit wr, logic [7:0] d, bit ld, int val, bit tick, bit md);
    if (wr) begin
      if (md) begin
        for (int r = 0; r < 4; r++) begin
          m_ram[r][wrapc(m_ptr)]     = d[7-r];
          m_ram[r][wrapc(m_ptr + 1)] = d[3-r];
        end
      end else begin
        for (int r = 0; r < 3; r++) begin
          m_ram[r][wrapc(m_ptr)]     = d[7-r];
          m_ram[r][wrapc(m_ptr + 1)] = d[4-r];
        end
        m_ram[0][wrapc(m_ptr + 2)] = d[1];
        m_ram[1][wrapc(m_ptr + 2)] = d[0];
      end
    end
    if (ld) m_ptr = (val < COLS) ? val : 0;
    else if (wr) m_ptr = wrapc(m_ptr + (md ? 2 : 3));
    if (md != m_modeq) m_row = 0;
    else if (tick) m_row = (m_row == (md ? 3 : 2)) ? 0 : m_row + 1;
    m_modeq = md;
  endtask

  task automatic op(string req, bit wr, logic [7:0] d, bit ld, int val, bit tick, bit md);
    wr_en = wr; wr_data = d; ptr_load = ld; ptr_val = PW'(val);
    frame_tick = tick; mode4 = md;
    @(posedge clk);
    model_step(wr, d, ld, val, tick, md);
    @(negedge clk);
    check_all(req);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; wr_en = 0; ptr_load = 0; frame_tick = 0; mode4 = 0;
    @(posedge clk); @(negedge clk);
    rst_n = 1;
    for (int r = 0; r < 4; r++) m_ram[r] = '0;
    m_ptr = 0; m_row = 0; m_modeq = 0;
  endtask

  task automatic goto_row(string req, int r, bit md);
    for (int i = 0; i < 5 && m_row != r; i++) op(req, 0, 8'h00, 0, 0, 1, md);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    do_reset();
    // R1 reset state
    check("R1", "ptr", int'(ptr), 0);
    check("R1", "row_idx", int'(row_idx), 0);
    check("R1", "row_data", int'(row_data), 0);

    // R2 R3 standard 1:3 filling with all ones
    for (int i = 0; i < 4; i++) op("R3", 1, 8'hFF, 0, 0, 0, 0);
    check("R3", "ptr after four bytes", int'(ptr), 0);
    check("R2", "row0", int'(row_data), 'hFFF);
    goto_row("R8", 2, 0);
    check("R3", "row2 unused cols", int'(row_data), 'h6DB);
    op("R8", 0, 8'h00, 0, 0, 1, 0);
    check("R8", "wrap to row0", int'(row_idx), 0);

    // R4 entire filling by rewinding
    do_reset();
    op("R4", 1, 8'h03, 0, 0, 0, 0);
    op("R4", 1, 8'hA0, 1, 2, 0, 0);
    check("R4", "ptr after overlapped write", int'(ptr), 2);
    op("R6", 0, 8'h00, 1, 2, 0, 0);
    op("R4", 1, 8'hA0, 0, 0, 0, 0);
    check("R4", "row0 col2 new bit7", int'(row_data[2]), 1);
    op("R4", 0, 8'h00, 0, 0, 1, 0);
    check("R4", "row1 col2 new bit6", int'(row_data[2]), 0);
    op("R4", 0, 8'h00, 0, 0, 1, 0);
    check("R4", "row2 col2 new bit5", int'(row_data[2]), 1);
    do_reset();
    for (int i = 0; i < 5; i++) op("R4", 1, 8'hFF, 1, 2 * i, 0, 0);
    for (int i = 0; i < 5; i++) begin
      op("R4", 0, 8'h00, 1, 2 * i, 0, 0);
      op("R4", 1, 8'hFF, 0, 0, 0, 0);
    end
    goto_row("R4", 2, 0);
    check("R4", "row2 fully filled", int'(row_data), 'h3FF);

    // R5 R9 1:4 packing and sequence
    do_reset();
    op("R10", 0, 8'h00, 0, 0, 0, 1);
    op("R5", 1, 8'hA5, 0, 0, 0, 1);
    check("R5", "ptr +2", int'(ptr), 2);
    check("R5", "row0 cols0,1", int'(row_data[1:0]), 'b01);
    for (int r = 1; r < 4; r++) op("R9", 0, 8'h00, 0, 0, 1, 1);
    check("R9", "row3 reached", int'(row_idx), 3);
    check("R5", "row3 cols0,1", int'(row_data[1:0]), 'b10);
    op("R9", 0, 8'h00, 0, 0, 1, 1);
    check("R9", "wrap to row0", int'(row_idx), 0);

    // R10 mode change with tick at row 3
    goto_row("R9", 3, 1);
    op("R10", 0, 8'h00, 0, 0, 1, 0);
    check("R10", "mode change over tick", int'(row_idx), 0);

    // R7 wrap and R6 out-of-range load
    do_reset();
    op("R6", 0, 8'h00, 1, COLS - 1, 0, 0);
    check("R6", "load value", int'(ptr), COLS - 1);
    op("R7", 1, 8'hFF, 0, 0, 0, 0);
    check("R7", "ptr wraps", int'(ptr), 2);
    check("R7", "row0 wrapped cols", int'(row_data), 'h803);
    op("R6", 0, 8'h00, 1, 15, 0, 0);
    check("R6", "out of range load", int'(ptr), 0);
    op("R6", 1, 8'h80, 1, 5, 0, 0);
    check("R6", "load beats advance", int'(ptr), 5);

    // R11 random mix, every op compared against the model
    for (int i = 0; i < 4000; i++) begin
      int k;
      bit md;
      k = $urandom_range(0, 99);
      md = (k < 3) ? ~m_modeq : m_modeq;
      op("R11", $urandom_range(0, 1) == 1, 8'($urandom), $urandom_range(0, 9) == 0,
         $urandom_range(0, 15), $urandom_range(0, 2) == 0, md);
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule